// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block is the transmit half of an asynchronous serial port. It has a one-byte holding register that software writes and a separate frame register that is shifted onto the line. Because of this split, the next byte can be queued while the current frame is still going out. Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit and a high stop bit. Every bit lasts sixteen pulses of an external oversampling tick.

Two flags carry the handshake with software. The holding-empty flag shows when the holding register can take a new byte. The transmit-done flag shows that the line has gone idle. The engine copies the holding register into the frame register whenever it is free to start a frame. It checks again at the moment the stop bit begins. If a byte is waiting at that moment, the byte is copied and its start bit follows the stop bit with no idle time. If no byte is waiting, the done flag is set and the line stays high. Each flag drives a level interrupt request that is gated by its own enable input.

Top module: `ser_tx_top`

## Requirements
- R1: Out of reset, the serial output is 1, the holding-empty flag is 1 and the transmit-done flag is 1.
- R2: A write pulse loads the holding register and clears both the holding-empty and transmit-done flags on that clock edge, so both read 0 in the following cycle. The write takes priority over any flag set on the same edge.
- R3: When the line is idle and the holding-empty flag is 0, the next clock edge copies the holding byte into the frame register and sets the holding-empty flag to 1. The output then goes to 0 for a start bit lasting 16 oversampling ticks.
- R4: After the start bit, the eight data bits go out least significant bit first. Each bit holds its value for exactly 16 oversampling ticks, and the output changes only at a bit boundary or at a frame start.
- R5: The parity mode is captured when the byte is copied. When parity is enabled, one parity bit follows D7: even mode sends the XOR of the eight data bits, and odd mode sends its inverse. When parity is disabled, the stop bit follows D7 directly.
- R6: The holding-empty flag is checked on the edge where the stop bit begins. If it is 0, the holding byte is copied and the flag is set to 1 on that edge. A 16-tick stop bit at 1 is sent, and the start bit of the new frame follows at once.
- R7: If the holding-empty flag is 1 when the stop bit begins, the transmit-done flag is set to 1 on that edge. After the stop bit, the output stays at 1 until new data is written.
- R8: The empty interrupt request equals the holding-empty flag ANDed with its enable input.
- R9: The done interrupt request equals the transmit-done flag ANDed with its enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to queue |
| par_en | input | 1 | 1 adds a parity bit to the frame |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| empty_ie | input | 1 | Enable for the empty interrupt request |
| done_ie | input | 1 | Enable for the done interrupt request |
| tx_line | output | 1 | Serial output, idles at 1 |
| hold_empty | output | 1 | Holding register can take a byte |
| tx_done | output | 1 | Last frame finished and no data was waiting |
| irq_empty | output | 1 | Empty interrupt request (level) |
| irq_done | output | 1 | Done interrupt request (level) |

## Verification
The hardest case to reach is a write that lands during the stop bit after the holding-empty check has already passed. In that case the done flag rises and falls again, and the byte must wait for a fresh start from idle instead of following the stop bit. The bench watches its reference model until the stop bit has begun and a few ticks have passed, then issues the write. Other tests write at a fixed offset into a frame, so that the stop-bit check finds a byte waiting. Those tests run with both a full-rate tick and a half-rate tick.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} tx_phase_e;

  // Parity over one frame's data: even is the XOR reduction, odd inverts it
  function automatic logic frame_parity(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/ser_tx_flags.sv
module ser_tx_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load_evt,
  input  logic         end_evt,
  output logic [W-1:0] hold_q,
  output logic         empty_q,
  output logic         done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      done_q  <= 1'b1;
    end else begin
      if (wr_en) begin
        hold_q  <= wr_data;
        empty_q <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        if (load_evt) empty_q <= 1'b1;
        if (end_evt)  done_q  <= 1'b1;
      end
    end
  end

  AST_WR_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!empty_q && !done_q)); // R2
  AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_en) |=> empty_q); // R3
  AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !empty_q); // R6
  AST_END_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |-> empty_q); // R7
endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq
  import ser_tx_pkg::*;
#(
  parameter int W   = 8,
  parameter int OSR = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         os_tick,
  input  logic [W-1:0] hold_q,
  input  logic         empty_q,
  input  logic         par_en,
  input  logic         par_odd,
  output logic         load_evt,
  output logic         end_evt,
  output logic         tx_line
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] TLAST = CW'(OSR - 1);
  localparam logic [IW-1:0] ILAST = IW'(W - 1);

  tx_phase_e     ph_q;
  logic [CW-1:0] tick_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  sh_q;
  logic          cfg_par_q, cfg_odd_q, pend_q;

  // Named internal events
  logic bit_end, stop_entry, idle_load;
  assign bit_end    = (ph_q != PH_IDLE) && os_tick && (tick_q == TLAST);
  assign stop_entry = bit_end && ((ph_q == PH_PAR) ||
                      (ph_q == PH_DATA && idx_q == ILAST && !cfg_par_q));
  assign idle_load  = (ph_q == PH_IDLE) && !empty_q;
  assign load_evt   = idle_load || (stop_entry && !empty_q);
  assign end_evt    = stop_entry && empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      tick_q    <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      cfg_par_q <= 1'b0;
      cfg_odd_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (load_evt) begin
        sh_q      <= hold_q;
        cfg_par_q <= par_en;
        cfg_odd_q <= par_odd;
      end
      if (ph_q == PH_IDLE) begin
        if (idle_load) begin
          ph_q   <= PH_START;
          tick_q <= '0;
        end
      end else if (os_tick) begin
        tick_q <= (tick_q == TLAST) ? '0 : tick_q + 1'b1;
      end
      if (stop_entry) pend_q <= !empty_q;
      if (bit_end) begin
        unique case (ph_q)
          PH_START: begin
            ph_q  <= PH_DATA;
            idx_q <= '0;
          end
          PH_DATA: begin
            if (idx_q == ILAST) ph_q <= cfg_par_q ? PH_PAR : PH_STOP;
            else                idx_q <= idx_q + 1'b1;
          end
          PH_PAR:  ph_q <= PH_STOP;
          PH_STOP: ph_q <= pend_q ? PH_START : PH_IDLE;
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_START: tx_line = 1'b0;
      PH_DATA:  tx_line = sh_q[idx_q];
      PH_PAR:   tx_line = frame_parity(sh_q, cfg_odd_q);
      default:  tx_line = 1'b1;
    endcase
  end

  AST_START_AFTER_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idle_load |=> !tx_line); // R3
  AST_LINE_HOLDS_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_end && !idle_load) |=> $stable(tx_line)); // R4
  AST_STOP_IS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    stop_entry |=> tx_line); // R6
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top #(
  parameter int W   = 8,
  parameter int OSR = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         os_tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         par_en,
  input  logic         par_odd,
  input  logic         empty_ie,
  input  logic         done_ie,
  output logic         tx_line,
  output logic         hold_empty,
  output logic         tx_done,
  output logic         irq_empty,
  output logic         irq_done
);
  logic [W-1:0] hold_q;
  logic         load_evt, end_evt;

  ser_tx_flags #(.W(W)) flags_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .load_evt(load_evt), .end_evt(end_evt),
    .hold_q(hold_q), .empty_q(hold_empty), .done_q(tx_done)
  );

  ser_tx_seq #(.W(W), .OSR(OSR)) seq_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .hold_q(hold_q),
    .empty_q(hold_empty), .par_en(par_en), .par_odd(par_odd),
    .load_evt(load_evt), .end_evt(end_evt), .tx_line(tx_line)
  );

  assign irq_empty = hold_empty & empty_ie;
  assign irq_done  = tx_done & done_ie;

  AST_IRQ_EMPTY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> (hold_empty && empty_ie)); // R8
  AST_IRQ_DONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (tx_done && done_ie)); // R9
endmodule

// File: tb/ser_tx_top_tb_top.sv
module ser_tx_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0, wr_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic empty_ie = 1'b0, done_ie = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic tx_line, hold_empty, tx_done, irq_empty, irq_done;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int half_rate = 0;

  always #5 clk = ~clk;

  ser_tx_top dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en), .wr_data(wr_data),
    .par_en(par_en), .par_odd(par_odd), .empty_ie(empty_ie), .done_ie(done_ie),
    .tx_line(tx_line), .hold_empty(hold_empty), .tx_done(tx_done),
    .irq_empty(irq_empty), .irq_done(irq_done)
  );

  // Reference model: phase -1 idle, 0 start, 1..8 data, 9 parity, 10 stop
  int m_phase = -1, m_ticks = 0;
  int m_hold = 0, m_frame = 0, m_empty = 1, m_done = 1, m_pend = 0;
  int m_par = 0, m_odd = 0;

  function automatic int par_bit(int d, int odd);
    int ones = 0;
    for (int k = 0; k < 8; k++) if (((d >> k) & 1) == 1) ones++;
    return (ones % 2) ^ odd;
  endfunction

  function automatic int m_line();
    if (m_phase == 0) return 0;
    if (m_phase >= 1 && m_phase <= 8) return (m_frame >> (m_phase - 1)) & 1;
    if (m_phase == 9) return par_bit(m_frame, m_odd);
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = -1; m_ticks = 0; m_hold = 0; m_frame = 0;
      m_empty = 1; m_done = 1; m_pend = 0; m_par = 0; m_odd = 0;
    end else begin
      if (m_phase == -1) begin
        if (m_empty == 0) begin
          m_frame = m_hold; m_par = par_en; m_odd = par_odd;
          m_empty = 1; m_phase = 0; m_ticks = 0;
        end
      end else if (os_tick) begin
        if (m_ticks < 15) m_ticks++;
        else begin
          m_ticks = 0;
          if (m_phase == 10) m_phase = m_pend ? 0 : -1;
          else begin
            if (m_phase == 8 && m_par == 1) m_phase = 9;
            else if (m_phase >= 8) m_phase = 10;
            else m_phase++;
            if (m_phase == 10) begin
              if (m_empty == 0) begin
                m_frame = m_hold; m_par = par_en; m_odd = par_odd;
                m_empty = 1; m_pend = 1;
              end else begin
                m_done = 1; m_pend = 0;
              end
            end
          end
        end
      end
      if (wr_en) begin m_hold = wr_data; m_empty = 0; m_done = 0; end
    end
  end

  task automatic cmp(input int act, input int exp, input string what, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic string line_req();
    if (m_phase == 0) return "R3";
    if (m_phase >= 1 && m_phase <= 8) return "R4";
    if (m_phase == 9) return "R5";
    if (m_phase == 10) return m_pend ? "R6" : "R7";
    return "R7";
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cmp(tx_line, m_line(), "tx_line", line_req());
      cmp(hold_empty, m_empty, "hold_empty", "R2");
      cmp(tx_done, m_done, "tx_done", "R7");
      cmp(irq_empty, m_empty & empty_ie, "irq_empty", "R8");
      cmp(irq_done, m_done & done_ie, "irq_done", "R9");
    end
  end

  // Tick source, driven on the falling edge
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv++;
    os_tick <= (half_rate == 0) ? 1'b1 : tdiv[0];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle_wait();
    int quiet = 0;
    while (quiet < 20) begin
      @(negedge clk);
      if (m_phase == -1 && m_empty == 1) quiet++; else quiet = 0;
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cycles(3);
    // R1: reset values while reset is held
    cmp(tx_line, 1, "reset tx_line", "R1");
    cmp(hold_empty, 1, "reset hold_empty", "R1");
    cmp(tx_done, 1, "reset tx_done", "R1");
    rst_n = 1'b1;
    empty_ie = 1'b1; done_ie = 1'b1;
    wait_cycles(4);
    // R3 R4 R7: single frame, no parity, full-rate tick
    put(8'hA5);
    idle_wait();
    // R5 R6: even parity, back-to-back frames
    par_en = 1'b1; par_odd = 1'b0;
    put(8'h3C); wait_cycles(30); put(8'hC3);
    idle_wait();
    // R5 R6: odd parity at half-rate tick
    half_rate = 1; par_odd = 1'b1;
    put(8'h01); wait_cycles(40); put(8'hFF);
    idle_wait();
    // R2 R7: write lands during stop bit after the check
    half_rate = 0; par_en = 1'b0;
    put(8'h55);
    while (!(m_phase == 10 && m_ticks > 3)) @(negedge clk);
    put(8'h81);
    idle_wait();
    // R8 R9: enables off, then on again
    empty_ie = 1'b0; done_ie = 1'b0;
    put(8'h7E); wait_cycles(50); done_ie = 1'b1;
    idle_wait();
    empty_ie = 1'b1;
    par_en = 1'b1; put(8'h00);
    idle_wait();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule